// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is one programmable cell of a lookup-table logic fabric. Four data inputs address a 16-entry truth table, so the cell can produce any Boolean function of four variables. An arithmetic mode replaces the table with a one-bit full-adder slice. Its carry input and carry output let neighbouring cells form adders, counters, accumulators and comparators.

The cell's result is available in two forms. It appears directly on a combinational output. It also feeds a single storage element, whose next state is set by a selectable flip-flop type: D, T, JK or SR. That element has a clock enable and a synchronous clear. The storage element can instead take its data from a register-chain input driven by the neighbouring cell. Its state is driven onward on a register-chain output.

All configuration is held inside the cell and written through a one-cycle load strobe:

- the truth-table word,
- the mode bit,
- the flip-flop type,
- the data-source select.

Top module: `lc_logic_cell`

## Requirements
- R1: While `rst` is high at a clock edge, the configuration returns to its defaults and the stored bit is cleared. The defaults are an all-zero table, logic mode, D type and table data source. After reset `comb_out`=0, `reg_out`=0 and `chain_out`=0.
- R2: In logic mode (`cfg_arith`=0), `comb_out` equals bit `din` of the table word. `din[0]` is the least significant index bit.
- R3: A clock edge with `cfg_load`=1 stores `cfg_lut`, `cfg_arith`, `cfg_ff_kind` and `cfg_from_chain`. The outputs follow the new settings in the cycle after that edge. With `cfg_load`=0, the stored configuration does not change.
- R4: In arithmetic mode (`cfg_arith`=1), `comb_out` = `din[0]` XOR `din[1]` XOR `cin`, and `cout` is the majority of `din[0]`, `din[1]` and `cin`. Neither the table word nor `din[3:2]` affects these outputs.
- R5: In logic mode, `cout` equals `cin`, so a carry passes through the cell unchanged.
- R6: With flip-flop type D (`cfg_ff_kind`=0), an enabled edge loads the data bit into `reg_out`.
- R7: With type T (`cfg_ff_kind`=1), an enabled edge inverts `reg_out` when the data bit is 1 and keeps it when the data bit is 0.
- R8: With type JK (`cfg_ff_kind`=2), J is `din[0]` and K is `din[1]`. On an enabled edge the codes act as follows: J=K=0 keeps the state, J=1 K=0 sets it, J=0 K=1 clears it, and J=K=1 inverts it.
- R9: With type SR (`cfg_ff_kind`=3), S is `din[0]` and R is `din[1]`. S alone sets the state and R alone clears it. Both low keeps the state, and both high also keeps it, since that is the illegal code.
- R10: When `cfg_from_chain`=1, the data bit for the D and T types comes from `chain_in` instead of from `comb_out`.
- R11: `clr` high at an edge clears `reg_out`, whatever `ce` is. With `clr`=0 and `ce`=0, `reg_out` holds its value.
- R12: `reg_out` changes only at clock edges, while `comb_out` follows `din` at once. `chain_out` always equals `reg_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Configuration write strobe |
| cfg_lut | input | 16 | Truth-table word to store |
| cfg_arith | input | 1 | Mode to store: 1 selects arithmetic |
| cfg_ff_kind | input | 2 | Flip-flop type to store: 0 D, 1 T, 2 JK, 3 SR |
| cfg_from_chain | input | 1 | Data source to store: 1 selects `chain_in` |
| din | input | 4 | Cell data inputs |
| cin | input | 1 | Carry from the previous cell |
| ce | input | 1 | Storage clock enable |
| clr | input | 1 | Synchronous clear of the stored bit |
| chain_in | input | 1 | Register-chain input from the neighbouring cell |
| comb_out | output | 1 | Unregistered cell result |
| reg_out | output | 1 | Registered cell state |
| cout | output | 1 | Carry to the next cell |
| chain_out | output | 1 | Register-chain output |

## Verification
Some behaviours are checked by assertions on every cycle:

- the arithmetic sum and carry, compared against an integer addition of the operands,
- the carry bypass in logic mode,
- the stability of the configuration without a load strobe,
- the precedence of clear over enable, and holding when the enable is low,
- the JK toggle and the SR hold on the illegal code.

Other behaviours can only be shown by the bench's scenarios:

- that every truth-table index reaches the right bit, with the input order taken into account,
- the exact cycle in which a new configuration takes effect,
- the full next-state sequences of the four flip-flop types,
- the switch to the register-chain source.

// File: rtl/lc_pkg.sv
package lc_pkg;

    localparam int LC_K     = 4;
    localparam int LC_LUT_W = 1 << LC_K;
    localparam int LC_KIND_W = 2;

    typedef enum logic [LC_KIND_W-1:0] {
        FF_D  = 2'd0,
        FF_T  = 2'd1,
        FF_JK = 2'd2,
        FF_SR = 2'd3
    } ff_kind_e;

    typedef enum logic {
        MODE_LOGIC = 1'b0,
        MODE_ARITH = 1'b1
    } cell_mode_e;

    typedef enum logic {
        DSRC_LUT   = 1'b0,
        DSRC_CHAIN = 1'b1
    } dsrc_e;

    typedef struct packed {
        logic [LC_LUT_W-1:0] lut;
        cell_mode_e          mode;
        ff_kind_e            kind;
        dsrc_e               dsrc;
    } cell_cfg_t;

    typedef struct packed {
        logic result;
        logic carry;
    } slice_out_t;

    localparam cell_cfg_t CFG_DEFAULT = '{
        lut:  '0,
        mode: MODE_LOGIC,
        kind: FF_D,
        dsrc: DSRC_LUT
    };

    // Majority of three bits: carry of a one-bit full adder.
    function automatic logic maj3(logic x, logic y, logic z);
        return (x & y) | (z & (x ^ y));
    endfunction

    // Next state of the storage element for each flip-flop type.
    // p0/p1 are the pair inputs (J/K or S/R) for the two-input types.
    function automatic logic ff_next(ff_kind_e kind, logic q, logic d,
                                     logic p0, logic p1);
        logic nq;
        unique case (kind)
            FF_D:  nq = d;
            FF_T:  nq = q ^ d;
            FF_JK: begin
                unique case ({p1, p0})
                    2'b00:   nq = q;
                    2'b01:   nq = 1'b1;
                    2'b10:   nq = 1'b0;
                    default: nq = ~q;
                endcase
            end
            default: begin
                unique case ({p1, p0})
                    2'b01:   nq = 1'b1;
                    2'b10:   nq = 1'b0;
                    default: nq = q;   // hold, and hold on the illegal code
                endcase
            end
        endcase
        return nq;
    endfunction

endpackage

// File: rtl/lc_cfg_store.sv
module lc_cfg_store
    import lc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  cell_cfg_t cfg_d,
    output cell_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_DEFAULT;
        else if (load)
            cfg_q <= cfg_d;
    end

    // R3: without a load strobe the stored configuration stays put
    p_cfg_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q));

    // R3: a load strobe lands the presented configuration
    p_cfg_lands_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (cfg_q == $past(cfg_d)));

endmodule

// File: rtl/lc_lut_arith.sv
module lc_lut_arith
    import lc_pkg::*;
#(
    parameter int K = LC_K
) (
    input  logic             [(1<<K)-1:0] lut,
    input  cell_mode_e                    mode,
    input  logic             [K-1:0]      din,
    input  logic                          cin,
    output slice_out_t                    sout
);

    localparam int W = 1 << K;

    // Binary mux tree: level g is selected by din[g], so din[0] is the
    // least significant index bit.
    logic [W-1:0] lvl [0:K];

    assign lvl[0] = lut;

    for (genvar g = 0; g < K; g++) begin : g_level
        localparam int N = W >> (g + 1);
        for (genvar j = 0; j < N; j++) begin : g_node
            assign lvl[g+1][j] = din[g] ? lvl[g][2*j+1] : lvl[g][2*j];
        end
        assign lvl[g+1][W-1:N] = '0;
    end

    logic lut_y;
    logic sum_y;
    logic carry_y;

    assign lut_y   = lvl[K][0];
    assign sum_y   = din[0] ^ din[1] ^ cin;
    assign carry_y = maj3(din[0], din[1], cin);

    always_comb begin
        if (mode == MODE_ARITH) begin
            sout.result = sum_y;
            sout.carry  = carry_y;
        end else begin
            sout.result = lut_y;
            sout.carry  = cin;
        end
    end

endmodule

// File: rtl/lc_storage.sv
module lc_storage
    import lc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     ce,
    input  ff_kind_e kind,
    input  logic     d,
    input  logic     p0,
    input  logic     p1,
    output logic     q
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= 1'b0;
        else if (ce)
            q <= ff_next(kind, q, d, p0, p1);
    end

    // R11: clear wins over enable
    p_clr_wins_r11: assert property (@(posedge clk) disable iff (rst)
        clr |=> !q);

    // R11: no enable, no change
    p_ce_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ce) |=> $stable(q));

    // R6: D type follows its data bit
    p_d_follow_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr && ce && kind == FF_D) |=> (q == $past(d)));

    // R8: JK with both inputs high inverts the state
    p_jk_toggle_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr && ce && kind == FF_JK && p0 && p1) |=> (q != $past(q)));

    // R9: SR with both inputs high is held
    p_sr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr && ce && kind == FF_SR && p0 && p1) |=> $stable(q));

endmodule

// File: rtl/lc_logic_cell.sv
module lc_logic_cell
    import lc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_load,
    input  logic [LC_LUT_W-1:0] cfg_lut,
    input  logic                cfg_arith,
    input  logic [LC_KIND_W-1:0] cfg_ff_kind,
    input  logic                cfg_from_chain,
    input  logic [LC_K-1:0]     din,
    input  logic                cin,
    input  logic                ce,
    input  logic                clr,
    input  logic                chain_in,
    output logic                comb_out,
    output logic                reg_out,
    output logic                cout,
    output logic                chain_out
);

    cell_cfg_t  cfg_next;
    cell_cfg_t  cfg_cur;
    slice_out_t slice;
    logic       data_bit;

    always_comb begin
        cfg_next.lut  = cfg_lut;
        cfg_next.mode = cell_mode_e'(cfg_arith);
        cfg_next.kind = ff_kind_e'(cfg_ff_kind);
        cfg_next.dsrc = dsrc_e'(cfg_from_chain);
    end

    lc_cfg_store u_cfg (
        .clk   (clk),
        .rst   (rst),
        .load  (cfg_load),
        .cfg_d (cfg_next),
        .cfg_q (cfg_cur)
    );

    lc_lut_arith #(.K(LC_K)) u_func (
        .lut  (cfg_cur.lut),
        .mode (cfg_cur.mode),
        .din  (din),
        .cin  (cin),
        .sout (slice)
    );

    assign data_bit = (cfg_cur.dsrc == DSRC_CHAIN) ? chain_in : slice.result;

    lc_storage u_ff (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .ce   (ce),
        .kind (cfg_cur.kind),
        .d    (data_bit),
        .p0   (din[0]),
        .p1   (din[1]),
        .q    (reg_out)
    );

    assign comb_out  = slice.result;
    assign cout      = slice.carry;
    assign chain_out = reg_out;

    // R4: arithmetic outputs equal the two-bit sum of the operands and carry
    p_arith_sum_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_cur.mode == MODE_ARITH) |->
            ({cout, comb_out} == (2'(din[0]) + 2'(din[1]) + 2'(cin))));

    // R5: carry bypass in logic mode
    p_carry_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_cur.mode == MODE_LOGIC) |-> (cout == cin));

endmodule

// File: tb/lc_logic_cell_tb.sv
`timescale 1ns/1ps
module lc_logic_cell_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_load;
    logic [15:0] cfg_lut;
    logic        cfg_arith;
    logic [1:0]  cfg_ff_kind;
    logic        cfg_from_chain;
    logic [3:0]  din;
    logic        cin;
    logic        ce;
    logic        clr;
    logic        chain_in;
    logic        comb_out;
    logic        reg_out;
    logic        cout;
    logic        chain_out;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lc_logic_cell dut_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_load       (cfg_load),
        .cfg_lut        (cfg_lut),
        .cfg_arith      (cfg_arith),
        .cfg_ff_kind    (cfg_ff_kind),
        .cfg_from_chain (cfg_from_chain),
        .din            (din),
        .cin            (cin),
        .ce             (ce),
        .clr            (clr),
        .chain_in       (chain_in),
        .comb_out       (comb_out),
        .reg_out        (reg_out),
        .cout           (cout),
        .chain_out      (chain_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock edge, returning at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_cfg(logic [15:0] lut, logic arith, logic [1:0] kind,
                            logic from_chain);
        ce             = 1'b0;
        cfg_lut        = lut;
        cfg_arith      = arith;
        cfg_ff_kind    = kind;
        cfg_from_chain = from_chain;
        cfg_load       = 1'b1;
        step();
        cfg_load       = 1'b0;
    endtask

    task automatic clear_reg();
        clr = 1'b1;
        step();
        clr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        din = 4'hB;
        cin = 1'b1;
        #1;
        chk("R1 comb_out after reset", comb_out, 1'b0);
        chk("R1 reg_out after reset", reg_out, 1'b0);
        chk("R1 chain_out after reset", chain_out, 1'b0);
        chk("R1 default logic mode carry bypass", cout, 1'b1);
    endtask

    task automatic t_lut();
        logic [15:0] words [4] = '{16'h8000, 16'h6996, 16'hA5C3, 16'h0001};
        foreach (words[w]) begin
            load_cfg(words[w], 1'b0, 2'd0, 1'b0);
            for (int i = 0; i < 16; i++) begin
                din = 4'(i);
                #1;
                chk("R2 table lookup", comb_out, words[w][i]);
            end
        end
    endtask

    task automatic t_cfg_timing();
        load_cfg(16'h0000, 1'b0, 2'd0, 1'b0);
        din = 4'h5;
        cfg_lut  = 16'h0020;
        cfg_load = 1'b1;
        #1;
        chk("R3 old config before edge", comb_out, 1'b0);
        step();
        cfg_load = 1'b0;
        chk("R3 new config after edge", comb_out, 1'b1);
        cfg_lut   = 16'h0000;
        cfg_arith = 1'b1;
        step();
        chk("R3 no load keeps table", comb_out, 1'b1);
        cin = 1'b1;
        #1;
        chk("R3 no load keeps mode", cout, 1'b1);
        cin = 1'b0;
        #1;
        chk("R3 no load keeps mode (cin low)", cout, 1'b0);
    endtask

    task automatic t_arith();
        logic [15:0] words [2] = '{16'hFFFF, 16'h0000};
        foreach (words[w]) begin
            load_cfg(words[w], 1'b1, 2'd0, 1'b0);
            for (int i = 0; i < 32; i++) begin
                logic a, b, c;
                logic [1:0] s;
                din = 4'(i >> 1);
                cin = i[0];
                a = din[0];
                b = din[1];
                c = cin;
                s = 2'(a) + 2'(b) + 2'(c);
                #1;
                chk("R4 arith sum", comb_out, s[0]);
                chk("R4 arith carry", cout, s[1]);
            end
        end
    endtask

    task automatic t_bypass();
        load_cfg(16'hFFFF, 1'b0, 2'd0, 1'b0);
        din = 4'h3;
        cin = 1'b0;
        #1;
        chk("R5 bypass cin=0", cout, 1'b0);
        cin = 1'b1;
        #1;
        chk("R5 bypass cin=1", cout, 1'b1);
    endtask

    task automatic t_dff();
        load_cfg(16'h0002, 1'b0, 2'd0, 1'b0);
        clear_reg();
        ce  = 1'b1;
        din = 4'h1;
        step();
        chk("R6 D loads 1", reg_out, 1'b1);
        chk("R12 chain_out mirrors reg_out", chain_out, 1'b1);
        ce  = 1'b0;
        din = 4'h0;
        #1;
        chk("R12 comb_out follows din", comb_out, 1'b0);
        chk("R12 reg_out waits for edge", reg_out, 1'b1);
        ce = 1'b1;
        step();
        chk("R6 D loads 0", reg_out, 1'b0);
        chk("R12 chain_out mirrors reg_out 0", chain_out, 1'b0);
    endtask

    task automatic t_tff();
        load_cfg(16'h0002, 1'b0, 2'd1, 1'b0);
        clear_reg();
        ce  = 1'b1;
        din = 4'h1;
        step();
        chk("R7 T toggles to 1", reg_out, 1'b1);
        step();
        chk("R7 T toggles to 0", reg_out, 1'b0);
        step();
        chk("R7 T toggles to 1 again", reg_out, 1'b1);
        din = 4'h0;
        step();
        chk("R7 T holds on 0", reg_out, 1'b1);
    endtask

    task automatic t_jk();
        logic [1:0] seq [6] = '{2'b01, 2'b00, 2'b10, 2'b11, 2'b11, 2'b00};
        logic exp_q;
        load_cfg(16'h0000, 1'b0, 2'd2, 1'b0);
        clear_reg();
        ce = 1'b1;
        exp_q = 1'b0;
        foreach (seq[s]) begin
            din = {2'b00, seq[s]};
            case (seq[s])
                2'b01: exp_q = 1'b1;
                2'b10: exp_q = 1'b0;
                2'b11: exp_q = ~exp_q;
                default: ;
            endcase
            step();
            chk("R8 JK next state", reg_out, exp_q);
        end
    endtask

    task automatic t_sr();
        logic [1:0] seq [6] = '{2'b01, 2'b00, 2'b11, 2'b10, 2'b11, 2'b01};
        logic exp_q;
        load_cfg(16'hFFFF, 1'b0, 2'd3, 1'b0);
        clear_reg();
        ce = 1'b1;
        exp_q = 1'b0;
        foreach (seq[s]) begin
            din = {2'b00, seq[s]};
            case (seq[s])
                2'b01: exp_q = 1'b1;
                2'b10: exp_q = 1'b0;
                default: ;
            endcase
            step();
            chk("R9 SR next state", reg_out, exp_q);
        end
    endtask

    task automatic t_chain();
        load_cfg(16'h0000, 1'b0, 2'd0, 1'b1);
        clear_reg();
        ce       = 1'b1;
        din      = 4'h0;
        chain_in = 1'b1;
        step();
        chk("R10 D takes chain_in 1", reg_out, 1'b1);
        chain_in = 1'b0;
        step();
        chk("R10 D takes chain_in 0", reg_out, 1'b0);
        load_cfg(16'h0000, 1'b0, 2'd1, 1'b1);
        ce       = 1'b1;
        chain_in = 1'b1;
        step();
        chk("R10 T toggles from chain_in", reg_out, 1'b1);
        chain_in = 1'b0;
        step();
        chk("R10 T holds with chain_in 0", reg_out, 1'b1);
    endtask

    task automatic t_clr_ce();
        load_cfg(16'hFFFF, 1'b0, 2'd0, 1'b0);
        ce = 1'b1;
        step();
        chk("R11 set before clear", reg_out, 1'b1);
        ce  = 1'b0;
        clr = 1'b1;
        step();
        chk("R11 clear with ce low", reg_out, 1'b0);
        clr = 1'b0;
        step();
        chk("R11 hold with ce low", reg_out, 1'b0);
        ce = 1'b1;
        step();
        chk("R11 load after hold", reg_out, 1'b1);
        clr = 1'b1;
        step();
        chk("R11 clear beats ce", reg_out, 1'b0);
        clr = 1'b0;
        ce  = 1'b0;
    endtask

    initial begin
        rst            = 1'b1;
        cfg_load       = 1'b0;
        cfg_lut        = '0;
        cfg_arith      = 1'b0;
        cfg_ff_kind    = '0;
        cfg_from_chain = 1'b0;
        din            = '0;
        cin            = 1'b0;
        ce             = 1'b0;
        clr            = 1'b0;
        chain_in       = 1'b0;
        @(negedge clk);
        t_reset();
        t_lut();
        t_cfg_timing();
        t_arith();
        t_bypass();
        t_dff();
        t_tff();
        t_jk();
        t_sr();
        t_chain();
        t_clr_ce();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule